// File: doc/BRIEF.md
# ECC Error Injection Control

This block is a control register that lets software plant deliberate single-bit or double-bit faults in four RAMs guarded by SECDED codes. The four RAMs are the register file, the instruction-cache tag store, the instruction-cache data store and the translation-buffer store. Each one is wrapped here with its own encoder, storage array and decoder. Software arms a target by writing a code into that target's two-bit field. The next write into the armed RAM then stores the word with one or two data bits inverted, and the field returns to zero on its own. A later read of that word shows the decoder at work: it corrects a single flip and reports it, and it flags a double flip as uncorrectable.

Each field is driven by a small state machine with three states. ARM_IDLE means nothing is armed and the field reads 00. ARM_ONE means a single flip is pending and the field reads 01. ARM_TWO means a double flip is pending and the field reads 10. There are three transitions. The first is a software write: the field's value is decoded, 01 leads to ARM_ONE, 10 leads to ARM_TWO, and 00 or 11 lead to ARM_IDLE. The second is a target write with no software write in the same cycle, which takes ARM_ONE or ARM_TWO back to ARM_IDLE. The third is hold: with neither event, the state keeps its value. A software write outranks a target write in the same cycle. The flip in that cycle still follows the state that held before the edge.

Top module: `ecc_inj_ctrl`

## Requirements
- R1: After reset every field reads 00 and `cfg_rdata` is zero.
- R2: The fields sit at `cfg_rdata` bits [1:0] for the register file, [3:2] for the cache tag store, [5:4] for the cache data store and [7:6] for the translation store. Writing 01 to a field makes it read 01 (single armed). Writing 10 makes it read 10 (double armed).
- R3: Writing 00 or 11 to a field leaves it reading 00, and no flip happens on the next target write. Bits [31:8] of `cfg_rdata` always read zero, whatever is written to them.
- R4: A write to a target RAM while its field is nonzero, with no register write in the same cycle, makes the field read 00 from the next cycle on.
- R5: A word stored under a single-flip arm reads back with its original value, and `*_corr` is high with `*_uncorr` low.
- R6: A word stored under a double-flip arm reads back with the two flipped bits still inverted, and `*_uncorr` is high with `*_corr` low.
- R7: Only the first target write after arming is altered. Data written later reads back unchanged and with both flags low.
- R8: Targets are independent. A write to one RAM clears only that RAM's field and never changes another field.
- R9: When a register write and a target write fall in the same cycle, the field takes the value that software wrote. The word written in that cycle is flipped according to the field value held before that cycle.
- R10: Flips land on data bits 0 and 1 of the register file and of both cache stores. In the translation store they land on bits `TLB_TAG_LSB` and `TLB_TAG_LSB+1`, which lie inside its tag part. Check bits are always computed from the unflipped data.
- R11: Read data and flags appear one cycle after `*_re`. A flag stays high only in that single cycle. A cycle that raises both `*_re` and `*_we` performs only the write and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| cfg_rdata | output | 32 | Control register read value |
| rf_we | input | 1 | Register-file RAM write |
| rf_re | input | 1 | Register-file RAM read request |
| rf_addr | input | RF_AW | Register-file RAM address |
| rf_wdata | input | RF_DW | Register-file RAM write data |
| rf_rdata | output | RF_DW | Register-file RAM corrected read data |
| rf_corr | output | 1 | Register-file single error corrected |
| rf_uncorr | output | 1 | Register-file double error detected |
| ict_we | input | 1 | Cache tag RAM write |
| ict_re | input | 1 | Cache tag RAM read request |
| ict_addr | input | ICT_AW | Cache tag RAM address |
| ict_wdata | input | ICT_DW | Cache tag RAM write data |
| ict_rdata | output | ICT_DW | Cache tag RAM read data |
| ict_corr | output | 1 | Cache tag single error corrected |
| ict_uncorr | output | 1 | Cache tag double error detected |
| icd_we | input | 1 | Cache data RAM write |
| icd_re | input | 1 | Cache data RAM read request |
| icd_addr | input | ICD_AW | Cache data RAM address |
| icd_wdata | input | ICD_DW | Cache data RAM write data |
| icd_rdata | output | ICD_DW | Cache data RAM read data |
| icd_corr | output | 1 | Cache data single error corrected |
| icd_uncorr | output | 1 | Cache data double error detected |
| tlb_we | input | 1 | Translation RAM write |
| tlb_re | input | 1 | Translation RAM read request |
| tlb_addr | input | TLB_AW | Translation RAM address |
| tlb_wdata | input | TLB_DW | Translation RAM write data |
| tlb_rdata | output | TLB_DW | Translation RAM read data |
| tlb_corr | output | 1 | Translation single error corrected |
| tlb_uncorr | output | 1 | Translation double error detected |

## Verification
A field state machine stuck armed, or one that clears too early, shows up in `cfg_rdata` on the very next cycle. It also shows up one read later as a flag raised on data that should be clean, or as no flag on data that should be faulty. A flip mask with the wrong bits or the wrong count changes both the returned word and the type of flag. It can therefore be seen one cycle after the read of the injected address. The bench sweeps every target, every field code and several data words. It also covers the collision case, the shared read/write cycle and the cross-target cases, and it computes every expected word and flag from the arm code and the flip position.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

    localparam int REG_W   = 32;
    localparam int FIELD_W = 2;
    localparam int N_TGT   = 4;
    localparam int USED_W  = FIELD_W * N_TGT;

    typedef enum logic [FIELD_W-1:0] {
        ARM_IDLE = 2'b00,
        ARM_ONE  = 2'b01,
        ARM_TWO  = 2'b10
    } arm_state_t;

    // Number of Hamming check bits for a data width.
    function automatic int secded_pw(int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Codeword position of data bit idx (positions that are powers of two hold check bits).
    function automatic int secded_pos(int idx);
        int pos;
        int cnt;
        pos = 2;
        cnt = -1;
        while (cnt < idx) begin
            pos++;
            if ((pos & (pos - 1)) != 0) cnt++;
        end
        return pos;
    endfunction

endpackage

// File: rtl/ecc_inj_arm.sv
module ecc_inj_arm
    import ecc_inj_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we,
    input  logic [FIELD_W-1:0] sw_val,
    input  logic               tgt_we,
    output logic [FIELD_W-1:0] field,
    output logic               inj_en,
    output logic               inj_dbl
);

    arm_state_t state_q;
    arm_state_t state_d;
    arm_state_t sw_state;

    always_comb begin
        unique case (sw_val)
            2'b01:   sw_state = ARM_ONE;
            2'b10:   sw_state = ARM_TWO;
            default: sw_state = ARM_IDLE;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (sw_we) begin
            state_d = sw_state;
        end else if (tgt_we) begin
            unique case (state_q)
                ARM_ONE,
                ARM_TWO:  state_d = ARM_IDLE;
                default:  state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        field   = state_q;
        inj_en  = 1'b0;
        inj_dbl = 1'b0;
        unique case (state_q)
            ARM_ONE: inj_en = tgt_we;
            ARM_TWO: begin
                inj_en  = tgt_we;
                inj_dbl = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ecc_secded_ram.sv
module ecc_secded_ram
    import ecc_inj_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 5,
    parameter int FLIP_LSB = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          inj_en,
    input  logic          inj_dbl,
    output logic [DW-1:0] rdata,
    output logic          corr,
    output logic          uncorr
);

    localparam int PW    = secded_pw(DW);
    localparam int SW    = DW + PW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] pos_tab [DW];

    for (genvar g = 0; g < DW; g++) begin : g_pos
        localparam int POS = secded_pos(g);
        assign pos_tab[g] = POS[PW-1:0];
    end

    logic [SW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_chk;
    logic [DW-1:0] flip;
    logic [SW-1:0] wr_word;
    logic [SW-1:0] rd_q;
    logic          rd_v;

    // Check bits from the clean word.
    always_comb begin
        wr_chk = '0;
        for (int i = 0; i < DW; i++) begin
            if (wdata[i]) wr_chk = wr_chk ^ pos_tab[i];
        end
    end

    always_comb begin
        flip = '0;
        if (inj_en) begin
            flip[FLIP_LSB] = 1'b1;
            if (inj_dbl) flip[FLIP_LSB+1] = 1'b1;
        end
    end

    assign wr_word = {(^wdata) ^ (^wr_chk), wr_chk, wdata ^ flip};

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v <= 1'b0;
            rd_q <= '0;
        end else begin
            rd_v <= re && !we;
            if (re && !we) rd_q <= mem[addr];
        end
    end

    logic [DW-1:0] rd_data;
    logic [PW-1:0] rd_chk;
    logic [PW-1:0] syn;
    logic          odd;
    logic [DW-1:0] fixed;

    assign rd_data = rd_q[DW-1:0];
    assign rd_chk  = rd_q[DW +: PW];
    assign odd     = ^rd_q;

    always_comb begin
        syn = rd_chk;
        for (int i = 0; i < DW; i++) begin
            if (rd_data[i]) syn = syn ^ pos_tab[i];
        end
    end

    always_comb begin
        fixed = rd_data;
        if (odd) begin
            for (int i = 0; i < DW; i++) begin
                if (syn == pos_tab[i]) fixed[i] = ~rd_data[i];
            end
        end
    end

    assign rdata  = fixed;
    assign corr   = rd_v && odd;
    assign uncorr = rd_v && !odd && (syn != '0);

endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int RF_DW       = 32,
    parameter int RF_AW       = 5,
    parameter int ICT_DW      = 20,
    parameter int ICT_AW      = 6,
    parameter int ICD_DW      = 32,
    parameter int ICD_AW      = 6,
    parameter int TLB_DW      = 24,
    parameter int TLB_AW      = 4,
    parameter int TLB_TAG_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              rf_we,
    input  logic              rf_re,
    input  logic [RF_AW-1:0]  rf_addr,
    input  logic [RF_DW-1:0]  rf_wdata,
    output logic [RF_DW-1:0]  rf_rdata,
    output logic              rf_corr,
    output logic              rf_uncorr,
    input  logic              ict_we,
    input  logic              ict_re,
    input  logic [ICT_AW-1:0] ict_addr,
    input  logic [ICT_DW-1:0] ict_wdata,
    output logic [ICT_DW-1:0] ict_rdata,
    output logic              ict_corr,
    output logic              ict_uncorr,
    input  logic              icd_we,
    input  logic              icd_re,
    input  logic [ICD_AW-1:0] icd_addr,
    input  logic [ICD_DW-1:0] icd_wdata,
    output logic [ICD_DW-1:0] icd_rdata,
    output logic              icd_corr,
    output logic              icd_uncorr,
    input  logic              tlb_we,
    input  logic              tlb_re,
    input  logic [TLB_AW-1:0] tlb_addr,
    input  logic [TLB_DW-1:0] tlb_wdata,
    output logic [TLB_DW-1:0] tlb_rdata,
    output logic              tlb_corr,
    output logic              tlb_uncorr
);

    localparam int T_RF  = 0;
    localparam int T_ICT = 1;
    localparam int T_ICD = 2;
    localparam int T_TLB = 3;

    logic [N_TGT-1:0]  tgt_we;
    logic [N_TGT-1:0]  inj_en;
    logic [N_TGT-1:0]  inj_dbl;
    logic [USED_W-1:0] fields;
    logic              unused_cfg_hi;

    assign tgt_we        = {tlb_we, icd_we, ict_we, rf_we};
    assign unused_cfg_hi = ^cfg_wdata[REG_W-1:USED_W];

    for (genvar t = 0; t < N_TGT; t++) begin : g_arm
        ecc_inj_arm u_arm (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_we   (cfg_we),
            .sw_val  (cfg_wdata[FIELD_W*t +: FIELD_W]),
            .tgt_we  (tgt_we[t]),
            .field   (fields[FIELD_W*t +: FIELD_W]),
            .inj_en  (inj_en[t]),
            .inj_dbl (inj_dbl[t])
        );
    end

    assign cfg_rdata = {{(REG_W-USED_W){1'b0}}, fields};

    ecc_secded_ram #(.DW(RF_DW), .AW(RF_AW), .FLIP_LSB(0)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .re(rf_re), .addr(rf_addr),
        .wdata(rf_wdata), .inj_en(inj_en[T_RF]), .inj_dbl(inj_dbl[T_RF]),
        .rdata(rf_rdata), .corr(rf_corr), .uncorr(rf_uncorr)
    );

    ecc_secded_ram #(.DW(ICT_DW), .AW(ICT_AW), .FLIP_LSB(0)) u_ict (
        .clk(clk), .rst_n(rst_n), .we(ict_we), .re(ict_re), .addr(ict_addr),
        .wdata(ict_wdata), .inj_en(inj_en[T_ICT]), .inj_dbl(inj_dbl[T_ICT]),
        .rdata(ict_rdata), .corr(ict_corr), .uncorr(ict_uncorr)
    );

    ecc_secded_ram #(.DW(ICD_DW), .AW(ICD_AW), .FLIP_LSB(0)) u_icd (
        .clk(clk), .rst_n(rst_n), .we(icd_we), .re(icd_re), .addr(icd_addr),
        .wdata(icd_wdata), .inj_en(inj_en[T_ICD]), .inj_dbl(inj_dbl[T_ICD]),
        .rdata(icd_rdata), .corr(icd_corr), .uncorr(icd_uncorr)
    );

    ecc_secded_ram #(.DW(TLB_DW), .AW(TLB_AW), .FLIP_LSB(TLB_TAG_LSB)) u_tlb (
        .clk(clk), .rst_n(rst_n), .we(tlb_we), .re(tlb_re), .addr(tlb_addr),
        .wdata(tlb_wdata), .inj_en(inj_en[T_TLB]), .inj_dbl(inj_dbl[T_TLB]),
        .rdata(tlb_rdata), .corr(tlb_corr), .uncorr(tlb_uncorr)
    );

endmodule

// File: rtl/ecc_inj_ctrl_chk.sv
module ecc_inj_ctrl_chk
    import ecc_inj_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic [N_TGT-1:0] we_v,
    input logic [N_TGT-1:0] re_v,
    input logic [N_TGT-1:0] corr_v,
    input logic [N_TGT-1:0] uncorr_v
);

    for (genvar t = 0; t < N_TGT; t++) begin : g_chk
        // R2
        arm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we && cfg_wdata[FIELD_W*t +: FIELD_W] == 2'b01
            |=> cfg_rdata[FIELD_W*t +: FIELD_W] == 2'b01);
        // R2
        arm_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we && cfg_wdata[FIELD_W*t +: FIELD_W] == 2'b10
            |=> cfg_rdata[FIELD_W*t +: FIELD_W] == 2'b10);
        // R3
        code_three_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we && cfg_wdata[FIELD_W*t +: FIELD_W] == 2'b11
            |=> cfg_rdata[FIELD_W*t +: FIELD_W] == 2'b00);
        // R4
        hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we && we_v[t] |=> cfg_rdata[FIELD_W*t +: FIELD_W] == 2'b00);
        // R8
        field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we && !we_v[t] |=> $stable(cfg_rdata[FIELD_W*t +: FIELD_W]));
        // R11
        flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(corr_v[t] && uncorr_v[t]));
        // R11
        flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (corr_v[t] || uncorr_v[t]) |-> $past(re_v[t] && !we_v[t]));
    end

endmodule

bind ecc_inj_ctrl ecc_inj_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .we_v      ({tlb_we, icd_we, ict_we, rf_we}),
    .re_v      ({tlb_re, icd_re, ict_re, rf_re}),
    .corr_v    ({tlb_corr, icd_corr, ict_corr, rf_corr}),
    .uncorr_v  ({tlb_uncorr, icd_uncorr, ict_uncorr, rf_uncorr})
);

// File: tb/ecc_inj_ctrl_bench.sv
module ecc_inj_ctrl_bench;

    localparam int TAG_LSB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    logic        rf_we = 0, rf_re = 0;
    logic [4:0]  rf_addr = '0;
    logic [31:0] rf_wdata = '0, rf_rdata;
    logic        rf_corr, rf_uncorr;
    logic        ict_we = 0, ict_re = 0;
    logic [5:0]  ict_addr = '0;
    logic [19:0] ict_wdata = '0, ict_rdata;
    logic        ict_corr, ict_uncorr;
    logic        icd_we = 0, icd_re = 0;
    logic [5:0]  icd_addr = '0;
    logic [31:0] icd_wdata = '0, icd_rdata;
    logic        icd_corr, icd_uncorr;
    logic        tlb_we = 0, tlb_re = 0;
    logic [3:0]  tlb_addr = '0;
    logic [23:0] tlb_wdata = '0, tlb_rdata;
    logic        tlb_corr, tlb_uncorr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ecc_inj_ctrl u_ecc_inj_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rf_we(rf_we), .rf_re(rf_re), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .rf_corr(rf_corr), .rf_uncorr(rf_uncorr),
        .ict_we(ict_we), .ict_re(ict_re), .ict_addr(ict_addr), .ict_wdata(ict_wdata),
        .ict_rdata(ict_rdata), .ict_corr(ict_corr), .ict_uncorr(ict_uncorr),
        .icd_we(icd_we), .icd_re(icd_re), .icd_addr(icd_addr), .icd_wdata(icd_wdata),
        .icd_rdata(icd_rdata), .icd_corr(icd_corr), .icd_uncorr(icd_uncorr),
        .tlb_we(tlb_we), .tlb_re(tlb_re), .tlb_addr(tlb_addr), .tlb_wdata(tlb_wdata),
        .tlb_rdata(tlb_rdata), .tlb_corr(tlb_corr), .tlb_uncorr(tlb_uncorr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] width_mask(input int t);
        case (t)
            1:       return 32'h000F_FFFF;
            3:       return 32'h00FF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int flip_lsb(input int t);
        return (t == 3) ? TAG_LSB : 0;
    endfunction

    task automatic drive_we(input int t, input logic v, input logic [5:0] a, input logic [31:0] d);
        case (t)
            0: begin rf_we = v;  rf_addr = a[4:0];  rf_wdata = d;        end
            1: begin ict_we = v; ict_addr = a;      ict_wdata = d[19:0]; end
            2: begin icd_we = v; icd_addr = a;      icd_wdata = d;       end
            default: begin tlb_we = v; tlb_addr = a[3:0]; tlb_wdata = d[23:0]; end
        endcase
    endtask

    task automatic drive_re(input int t, input logic v, input logic [5:0] a);
        case (t)
            0: begin rf_re = v;  rf_addr = a[4:0]; end
            1: begin ict_re = v; ict_addr = a;     end
            2: begin icd_re = v; icd_addr = a;     end
            default: begin tlb_re = v; tlb_addr = a[3:0]; end
        endcase
    endtask

    task automatic sample(input int t, output logic [31:0] d, output logic c, output logic u);
        case (t)
            0: begin d = rf_rdata;         c = rf_corr;  u = rf_uncorr;  end
            1: begin d = {12'h0, ict_rdata}; c = ict_corr; u = ict_uncorr; end
            2: begin d = icd_rdata;        c = icd_corr; u = icd_uncorr; end
            default: begin d = {8'h0, tlb_rdata}; c = tlb_corr; u = tlb_uncorr; end
        endcase
    endtask

    task automatic cfg_write(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ram_write(input int t, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        drive_we(t, 1'b1, a, d);
        @(negedge clk);
        drive_we(t, 1'b0, a, d);
    endtask

    task automatic ram_read(input int t, input logic [5:0] a, output logic [31:0] d, output logic c, output logic u);
        @(negedge clk);
        drive_re(t, 1'b1, a);
        @(negedge clk);
        drive_re(t, 1'b0, a);
        sample(t, d, c, u);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, rd, expd;
        logic c, u;
        logic [5:0] a;
        int ef;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 32'h0, "R1 reset", cfg_rdata, 32'h0);

        // Sweep targets, arm codes and data words: R2 R3 R4 R5 R6 R7 R10 R11
        for (int t = 0; t < 4; t++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 3; p++) begin
                    d  = (32'h9E37_79B9 * (t * 16 + m * 4 + p + 1)) & width_mask(t);
                    a  = 6'((t * 5 + m * 3 + p) & 15);
                    ef = (m == 1 || m == 2) ? m : 0;
                    cfg_write(32'hFFFF_FF00 | (32'(m) << (2 * t)));
                    check(cfg_rdata[2*t +: 2] == 2'(ef), "R2 R3 field after write",
                          32'(cfg_rdata[2*t +: 2]), 32'(ef));
                    check(cfg_rdata[31:8] == 24'h0, "R3 reserved bits", cfg_rdata, 32'h0);
                    ram_write(t, a, d);
                    check(cfg_rdata == 32'h0, "R4 field cleared", cfg_rdata, 32'h0);
                    ram_read(t, a, rd, c, u);
                    expd = (m == 2) ? (d ^ (32'h3 << flip_lsb(t))) : d;
                    check(rd == expd, "R5 R6 R10 read data", rd, expd);
                    check(c == (m == 1), "R5 corrected flag", 32'(c), 32'(m == 1));
                    check(u == (m == 2), "R6 uncorrectable flag", 32'(u), 32'(m == 2));
                    @(negedge clk);
                    sample(t, rd, c, u);
                    check(!c && !u, "R11 flag one cycle", {30'h0, c, u}, 32'h0);
                    ram_write(t, a, d);
                    ram_read(t, a, rd, c, u);
                    check(rd == d && !c && !u, "R7 later write clean", rd, d);
                end
            end
        end

        // R8 independence
        cfg_write(32'h55);
        check(cfg_rdata == 32'h55, "R8 all armed", cfg_rdata, 32'h55);
        ram_write(1, 6'd9, 32'h1234);
        check(cfg_rdata == 32'h51, "R8 only tag field cleared", cfg_rdata, 32'h51);
        ram_write(3, 6'd2, 32'h5A5A);
        check(cfg_rdata == 32'h11, "R8 only translation field cleared", cfg_rdata, 32'h11);
        ram_write(0, 6'd3, 32'hCAFE_0001);
        check(cfg_rdata == 32'h10, "R8 only regfile field cleared", cfg_rdata, 32'h10);
        cfg_write(32'h0);

        // R9 collision: double armed, software writes single in the same cycle as a target write
        cfg_write(32'h2);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'h1;
        drive_we(0, 1'b1, 6'd7, 32'h0F0F_1234);
        @(negedge clk);
        cfg_we = 1'b0;
        drive_we(0, 1'b0, 6'd7, 32'h0F0F_1234);
        check(cfg_rdata[1:0] == 2'b01, "R9 software wins", cfg_rdata, 32'h1);
        ram_read(0, 6'd7, rd, c, u);
        check(rd == (32'h0F0F_1234 ^ 32'h3) && u, "R9 old double arm applied", rd, 32'h0F0F_1234 ^ 32'h3);
        ram_write(0, 6'd8, 32'h0000_BEEF);
        check(cfg_rdata == 32'h0, "R9 new arm then cleared", cfg_rdata, 32'h0);
        ram_read(0, 6'd8, rd, c, u);
        check(rd == 32'h0000_BEEF && c && !u, "R9 single applied", rd, 32'h0000_BEEF);

        // R11 read and write in the same cycle: write only
        cfg_write(32'h10);
        @(negedge clk);
        drive_we(2, 1'b1, 6'd20, 32'h7777_0000);
        icd_re = 1'b1;
        @(negedge clk);
        drive_we(2, 1'b0, 6'd20, 32'h7777_0000);
        icd_re = 1'b0;
        check(!icd_corr && !icd_uncorr, "R11 no flag on shared cycle",
              {30'h0, icd_corr, icd_uncorr}, 32'h0);
        check(cfg_rdata == 32'h0, "R4 shared cycle write cleared field", cfg_rdata, 32'h0);
        ram_read(2, 6'd20, rd, c, u);
        check(rd == 32'h7777_0000 && c, "R11 shared cycle write landed", rd, 32'h7777_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule